// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block sequences the calibration of a sampling converter. A calibration is requested either by a pulse on the calibration pin or by a one-cycle software start strobe. The pulse's falling edge resets the block internally, and the calibration begins on its rising edge. A three-bit mode input selects between self and system calibration and among four kinds: full, gain+offset, offset-only and gain-only. The block then steps through its phases (DAC trim, gain trim, offset trim) and holds BUSY high while it does. Each phase lasts a parameter number of master-clock cycles, which stands in for the analog trim completing.

A self calibration keeps BUSY high without a break across all of its phases. A system calibration that includes an offset phase behaves differently. After the DAC and gain work, BUSY drops and the block waits for a rising edge on the convert-start input. This gives the system time to apply its offset voltage before that edge raises BUSY again for the offset phase. The current phase is reported as a code, and a one-hot trim strobe and a trim target level drive an abstract trim interface. A one-cycle done pulse marks the end of a calibration.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, busy_o is 0, phase_o is 0 (idle), done_o is 0, trim_sel_o is 0 and trim_point_o is 0.
- R2: A falling edge on cal_pin_i aborts any calibration in progress. From the next cycle phase_o is idle and busy_o is 0, and no done pulse is produced.
- R3: In idle, a rising edge on cal_pin_i or sw_start_i high starts a calibration, and busy_o is high in the first cycle after the clock edge that samples the request.
- R4: cal_mode_i encoding: bit 2 selects system (1) or self (0); bits 1:0 select 00 full, 01 gain+offset, 10 offset-only, 11 gain-only. A full self calibration runs DAC, then gain, then offset, with busy_o high for DAC_CYC+GAIN_CYC+OFFSET_CYC cycles without a break.
- R5: A self gain+offset calibration runs gain then offset, with busy_o high for GAIN_CYC+OFFSET_CYC cycles without a break.
- R6: Offset-only runs one offset phase of OFFSET_CYC cycles, and gain-only runs one gain phase of GAIN_CYC cycles, in both self and system mode.
- R7: A system full or gain+offset calibration drops busy_o after its gain phase and enters the wait phase. It stays there with busy_o low until a rising edge on convst_i, which starts the offset phase of OFFSET_CYC cycles.
- R8: convst_i edges have no effect outside the wait phase.
- R9: Start requests arrive in any non-idle phase (busy or waiting) are ignored. The mode and polarity used are those sampled at the start, so changes while running have no effect.
- R10: done_o is high for exactly one cycle, the first cycle with busy_o low after the final phase. It does not pulse on entering the wait phase or on an abort.
- R11: Phase codes are 0 idle, 1 DAC, 2 gain, 3 wait, 4 offset. trim_sel_o is one-hot: bit 0 in DAC, bit 1 in gain, bit 2 in offset, otherwise 0. trim_point_o is 3 (full scale) in gain, and in offset it is 2 (midscale) when bipolar or 1 (zero scale) when unipolar. In every other phase trim_point_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_pin_i | input | 1 | Calibration pin: falling edge aborts, rising edge starts |
| sw_start_i | input | 1 | One-cycle software start strobe |
| cal_mode_i | input | 3 | Calibration mode, see R4 |
| bipolar_i | input | 1 | Input range polarity: 1 bipolar, 0 unipolar |
| convst_i | input | 1 | Convert start; a rising edge releases the offset phase |
| busy_o | output | 1 | High while a trim phase is running |
| phase_o | output | 3 | Current phase code |
| done_o | output | 1 | One-cycle end-of-calibration pulse |
| trim_sel_o | output | 3 | One-hot trim strobe {offset, gain, DAC} |
| trim_point_o | output | 2 | Trim target level |

## Verification
The bench builds the block with DAC_CYC=7, GAIN_CYC=5 and OFFSET_CYC=4. The full default lengths run into the hundreds of thousands of cycles, and these short, distinct lengths keep every kind of calibration to a few dozen cycles. Because the lengths differ, a phase that runs too long, too short or in the wrong order changes the measured BUSY width. The short lengths also give room for aborts in mid-phase, for starts issued during busy and during the wait phase, and for convert-start edges applied both before and inside the wait phase.

// File: rtl/adc_cal_pkg.sv
// Package: shared types for the calibration sequencer.
// Holds the phase codes, calibration kinds, trim target levels and the
// configuration record latched at the start of a calibration.
package adc_cal_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_DAC    = 3'd1,
        PH_GAIN   = 3'd2,
        PH_WAIT   = 3'd3,
        PH_OFFSET = 3'd4
    } cal_phase_e;

    typedef enum logic [1:0] {
        CT_FULL     = 2'd0,
        CT_GAIN_OFF = 2'd1,
        CT_OFF      = 2'd2,
        CT_GAIN     = 2'd3
    } cal_type_e;

    typedef enum logic [1:0] {
        TP_NONE = 2'd0,
        TP_ZERO = 2'd1,
        TP_MID  = 2'd2,
        TP_FULL = 2'd3
    } trim_point_e;

    typedef struct packed {
        logic      sys;
        cal_type_e kind;
        logic      bipolar;
    } cal_cfg_t;

endpackage

// File: rtl/adc_cal_edge.sv
// Module: single-bit edge detector.
// Registers the input once and flags either its rising or its falling
// edge, chosen by FALLING. Assumes the input is already synchronous to clk.
// During reset the history register follows the input, so that no edge
// is reported at reset release.
module adc_cal_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);

    logic prev_q;

    // History register for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= sig_i;
        end else begin
            prev_q <= sig_i;
        end
    end

    // Edge flag; the variant is picked by parameter.
    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev_q & ~sig_i;
        end else begin : g_rise
            assign edge_o = ~prev_q & sig_i;
        end
    endgenerate

endmodule

// File: rtl/adc_cal_timer.sv
// Module: phase length timer.
// It loads len_i, which is the phase length minus one, when the sequencer
// enters a timed phase. After that it counts down to zero. last_o is high
// on the final cycle of the phase. Assumes that load_i is pulsed exactly
// on phase entry.
module adc_cal_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          last_o
);

    logic [CW-1:0] cnt_q;

    // Down counter; stops at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);

    // R4: the counter steps down by exactly one per cycle unless reloaded.
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_cal_fsm.sv
// Module: calibration phase sequencer.
// It latches the configuration when a start is accepted in idle and then
// steps through the phases the kind requires. For a system calibration
// with an offset phase, it parks in the wait phase until a convert-start
// edge. An abort returns it to idle at once. The timer is loaded here and
// timed out by the caller's timer. Assumes that every phase length is at
// least one cycle.
module adc_cal_fsm
    import adc_cal_pkg::*;
#(
    parameter int CW         = 18,
    parameter int DAC_CYC    = 194430,
    parameter int GAIN_CYC   = 27798,
    parameter int OFFSET_CYC = 27798
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req_i,
    input  logic          abort_i,
    input  logic          cv_rise_i,
    input  cal_cfg_t      cfg_i,
    input  logic          tmr_last_i,
    output cal_phase_e    phase_o,
    output cal_cfg_t      cfg_o,
    output logic          done_o,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_len_o
);

    localparam logic [CW-1:0] DAC_LEN    = CW'(DAC_CYC - 1);
    localparam logic [CW-1:0] GAIN_LEN   = CW'(GAIN_CYC - 1);
    localparam logic [CW-1:0] OFFSET_LEN = CW'(OFFSET_CYC - 1);

    cal_phase_e ph_q, ph_d;
    cal_cfg_t   cfg_q;
    logic       done_q, done_d;
    logic       load_cfg;

    // Opening phase for each calibration kind.
    function automatic cal_phase_e first_phase(cal_type_e k);
        case (k)
            CT_FULL:     return PH_DAC;
            CT_GAIN_OFF: return PH_GAIN;
            CT_GAIN:     return PH_GAIN;
            default:     return PH_OFFSET;
        endcase
    endfunction

    // Phase that follows the gain phase for the latched configuration.
    function automatic cal_phase_e after_gain(cal_cfg_t c);
        if (c.kind == CT_GAIN) begin
            return PH_IDLE;
        end else if (c.sys) begin
            return PH_WAIT;
        end
        return PH_OFFSET;
    endfunction

    // Timer reload value for a phase being entered.
    function automatic logic [CW-1:0] phase_len(cal_phase_e p);
        case (p)
            PH_DAC:    return DAC_LEN;
            PH_GAIN:   return GAIN_LEN;
            PH_OFFSET: return OFFSET_LEN;
            default:   return '0;
        endcase
    endfunction

    // Whether a phase is timed (BUSY high).
    function automatic logic timed(cal_phase_e p);
        return (p == PH_DAC) || (p == PH_GAIN) || (p == PH_OFFSET);
    endfunction

    // Next-phase decision.
    always_comb begin
        ph_d     = ph_q;
        load_cfg = 1'b0;
        if (abort_i) begin
            ph_d = PH_IDLE;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start_req_i) begin
                        ph_d     = first_phase(cfg_i.kind);
                        load_cfg = 1'b1;
                    end
                end
                PH_DAC:    if (tmr_last_i) ph_d = PH_GAIN;
                PH_GAIN:   if (tmr_last_i) ph_d = after_gain(cfg_q);
                PH_WAIT:   if (cv_rise_i)  ph_d = PH_OFFSET;
                PH_OFFSET: if (tmr_last_i) ph_d = PH_IDLE;
                default:   ph_d = PH_IDLE;
            endcase
        end
        done_d = !abort_i && timed(ph_q) && (ph_d == PH_IDLE);
    end

    assign tmr_load_o = (ph_d != ph_q) && timed(ph_d);
    assign tmr_len_o  = phase_len(ph_d);

    // Phase and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            done_q <= done_d;
        end
    end

    // Configuration latch, written only when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load_cfg) begin
            cfg_q <= cfg_i;
        end
    end

    assign phase_o = ph_q;
    assign cfg_o   = cfg_q;
    assign done_o  = done_q;

    // R3: an accepted start leaves idle on the next cycle.
    p_start_leaves_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_IDLE && start_req_i && !abort_i) |=> (ph_q != PH_IDLE));

    // R2: an abort lands in idle without a done pulse.
    p_abort_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (ph_q == PH_IDLE && !done_q));

    // R10: done lasts one cycle and only appears in idle.
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_in_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (ph_q == PH_IDLE));

    // R9: the latched configuration holds while a calibration runs.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_IDLE) |=> $stable(cfg_q));

    // R7/R8: the wait phase is left only by a convert-start edge or an abort.
    p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_WAIT && !cv_rise_i && !abort_i) |=> (ph_q == PH_WAIT));

endmodule

// File: rtl/adc_cal_seq.sv
// Module: calibration sequencer top.
// Detects the pin and convert-start edges, runs the phase sequencer and
// its timer, and decodes BUSY plus the trim strobe and target. Assumes
// that all inputs are synchronous to clk and that sw_start_i is a one-cycle
// strobe issued at the end of a register write.
module adc_cal_seq
    import adc_cal_pkg::*;
#(
    parameter int DAC_CYC    = 194430,
    parameter int GAIN_CYC   = 27798,
    parameter int OFFSET_CYC = 27798
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cal_pin_i,
    input  logic       sw_start_i,
    input  logic [2:0] cal_mode_i,
    input  logic       bipolar_i,
    input  logic       convst_i,
    output logic       busy_o,
    output logic [2:0] phase_o,
    output logic       done_o,
    output logic [2:0] trim_sel_o,
    output logic [1:0] trim_point_o
);

    localparam int MAX_AB = (DAC_CYC > GAIN_CYC) ? DAC_CYC : GAIN_CYC;
    localparam int MAX_C  = (MAX_AB > OFFSET_CYC) ? MAX_AB : OFFSET_CYC;
    localparam int CW     = $clog2(MAX_C + 1);

    logic          cal_rise, cal_fall, cv_rise;
    logic          start_req;
    logic          tmr_load, tmr_last;
    logic [CW-1:0] tmr_len;
    cal_cfg_t      cfg_in, cfg_q;
    cal_phase_e    phase;

    adc_cal_edge #(.FALLING(1'b0)) u_cal_rise (
        .clk(clk), .rst_n(rst_n), .sig_i(cal_pin_i), .edge_o(cal_rise));
    adc_cal_edge #(.FALLING(1'b1)) u_cal_fall (
        .clk(clk), .rst_n(rst_n), .sig_i(cal_pin_i), .edge_o(cal_fall));
    adc_cal_edge #(.FALLING(1'b0)) u_cv_rise (
        .clk(clk), .rst_n(rst_n), .sig_i(convst_i), .edge_o(cv_rise));

    // Configuration record taken from the mode pins.
    always_comb begin
        cfg_in.sys     = cal_mode_i[2];
        cfg_in.kind    = cal_type_e'(cal_mode_i[1:0]);
        cfg_in.bipolar = bipolar_i;
    end

    assign start_req = cal_rise | sw_start_i;

    adc_cal_fsm #(
        .CW(CW), .DAC_CYC(DAC_CYC), .GAIN_CYC(GAIN_CYC), .OFFSET_CYC(OFFSET_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_req_i(start_req), .abort_i(cal_fall), .cv_rise_i(cv_rise),
        .cfg_i(cfg_in), .tmr_last_i(tmr_last),
        .phase_o(phase), .cfg_o(cfg_q), .done_o(done_o),
        .tmr_load_o(tmr_load), .tmr_len_o(tmr_len)
    );

    adc_cal_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .len_i(tmr_len),
        .last_o(tmr_last)
    );

    // Output decode: busy, trim strobe and trim target.
    always_comb begin
        busy_o       = 1'b0;
        trim_sel_o   = 3'b000;
        trim_point_o = TP_NONE;
        case (phase)
            PH_DAC: begin
                busy_o     = 1'b1;
                trim_sel_o = 3'b001;
            end
            PH_GAIN: begin
                busy_o       = 1'b1;
                trim_sel_o   = 3'b010;
                trim_point_o = TP_FULL;
            end
            PH_OFFSET: begin
                busy_o       = 1'b1;
                trim_sel_o   = 3'b100;
                trim_point_o = cfg_q.bipolar ? TP_MID : TP_ZERO;
            end
            default: ;
        endcase
    end

    assign phase_o = phase;

    // R11: at most one trim strobe, and a strobe exactly while busy.
    p_trim_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trim_sel_o) && (busy_o == (trim_sel_o != 3'b000)));

    // R10: done follows a busy cycle.
    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !cal_fall |=> (done_o |-> !busy_o));

endmodule

// File: tb/adc_cal_seq_tb_top.sv
module adc_cal_seq_tb_top;

    localparam int DAC_CYC    = 7;
    localparam int GAIN_CYC   = 5;
    localparam int OFFSET_CYC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_pin = 1'b1;
    logic       sw_start = 1'b0;
    logic [2:0] cal_mode = 3'b000;
    logic       bipolar = 1'b0;
    logic       convst = 1'b0;
    logic       busy;
    logic [2:0] phase;
    logic       done;
    logic [2:0] trim_sel;
    logic [1:0] trim_point;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int busy_cnt = 0;
    int done_cnt = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    adc_cal_seq #(
        .DAC_CYC(DAC_CYC), .GAIN_CYC(GAIN_CYC), .OFFSET_CYC(OFFSET_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cal_pin_i(cal_pin), .sw_start_i(sw_start),
        .cal_mode_i(cal_mode), .bipolar_i(bipolar), .convst_i(convst),
        .busy_o(busy), .phase_o(phase), .done_o(done),
        .trim_sel_o(trim_sel), .trim_point_o(trim_point)
    );

    // Behavioural reference: a queue of pending phases and their lengths.
    int m_ph = 0;
    int m_cnt = 0;
    bit m_done = 0;
    bit m_bip = 0;
    bit prev_cal = 1;
    bit prev_cv = 0;
    int q_ph[$];
    int q_len[$];

    task automatic m_pop();
        m_ph  = q_ph.pop_front();
        m_cnt = q_len.pop_front();
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_done = 0; q_ph.delete(); q_len.delete();
            prev_cal = cal_pin; prev_cv = convst;
        end else begin
            m_done = 0;
            if (prev_cal && !cal_pin) begin
                m_ph = 0; q_ph.delete(); q_len.delete();
            end else if (m_ph == 0) begin
                if ((!prev_cal && cal_pin) || sw_start) begin
                    m_bip = bipolar;
                    case (cal_mode[1:0])
                        2'd0: begin
                            q_ph.push_back(1); q_len.push_back(DAC_CYC);
                            q_ph.push_back(2); q_len.push_back(GAIN_CYC);
                            if (cal_mode[2]) begin q_ph.push_back(3); q_len.push_back(0); end
                            q_ph.push_back(4); q_len.push_back(OFFSET_CYC);
                        end
                        2'd1: begin
                            q_ph.push_back(2); q_len.push_back(GAIN_CYC);
                            if (cal_mode[2]) begin q_ph.push_back(3); q_len.push_back(0); end
                            q_ph.push_back(4); q_len.push_back(OFFSET_CYC);
                        end
                        2'd2: begin q_ph.push_back(4); q_len.push_back(OFFSET_CYC); end
                        default: begin q_ph.push_back(2); q_len.push_back(GAIN_CYC); end
                    endcase
                    m_pop();
                end
            end else if (m_ph == 3) begin
                if (!prev_cv && convst) m_pop();
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (q_ph.size() == 0) begin
                        m_ph = 0; m_done = 1;
                    end else begin
                        m_pop();
                    end
                end
            end
            prev_cal = cal_pin;
            prev_cv  = convst;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int e_busy, e_sel, e_pt;
            e_busy = (m_ph == 1 || m_ph == 2 || m_ph == 4);
            e_sel  = (m_ph == 1) ? 1 : (m_ph == 2) ? 2 : (m_ph == 4) ? 4 : 0;
            e_pt   = (m_ph == 2) ? 3 : (m_ph == 4) ? (m_bip ? 2 : 1) : 0;
            chk(cur_req, "busy", busy, e_busy);
            chk(cur_req, "phase", phase, m_ph);
            chk("R10", "done", done, m_done);
            chk("R11", "trim_sel", trim_sel, e_sel);
            chk("R11", "trim_point", trim_point, e_pt);
            if (busy) busy_cnt++;
            if (done) done_cnt++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic sw_go(string req);
        sw_start = 1'b1;
        step(1);
        sw_start = 1'b0;
        chk(req, "busy after start", busy, 1);
    endtask

    task automatic pin_go(string req);
        cal_pin = 1'b0;
        step(2);
        cal_pin = 1'b1;
        step(1);
        chk(req, "busy after pin rise", busy, 1);
    endtask

    task automatic wait_phase(int p);
        for (int i = 0; i < 200; i++) begin
            if (phase == p) break;
            step(1);
        end
    endtask

    task automatic clear_counts();
        busy_cnt = 0;
        done_cnt = 0;
    endtask

    initial begin
        step(3);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset phase", phase, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset trim", {trim_sel, trim_point}, 0);
        rst_n = 1'b1;
        step(2);

        // R4 full self calibration via the pin (R3).
        cur_req = "R4"; cal_mode = 3'b000; clear_counts();
        pin_go("R3");
        wait_phase(0); step(2);
        chk("R4", "busy width", busy_cnt, DAC_CYC + GAIN_CYC + OFFSET_CYC);
        chk("R10", "done count", done_cnt, 1);

        // R5 self gain+offset via software.
        cur_req = "R5"; cal_mode = 3'b001; clear_counts();
        sw_go("R3");
        wait_phase(0); step(2);
        chk("R5", "busy width", busy_cnt, GAIN_CYC + OFFSET_CYC);

        // R6 single-phase kinds, self and system.
        cur_req = "R6"; cal_mode = 3'b010; clear_counts();
        sw_go("R6"); wait_phase(0); step(2);
        chk("R6", "offset width", busy_cnt, OFFSET_CYC);
        cal_mode = 3'b011; clear_counts();
        sw_go("R6"); wait_phase(0); step(2);
        chk("R6", "gain width", busy_cnt, GAIN_CYC);
        cal_mode = 3'b110; clear_counts();
        sw_go("R6"); wait_phase(0); step(2);
        chk("R6", "sys offset width", busy_cnt, OFFSET_CYC);
        chk("R6", "sys offset no wait", phase, 0);

        // R7/R8 full system calibration with an early convst pulse.
        cur_req = "R7"; cal_mode = 3'b100; clear_counts();
        sw_go("R7");
        step(2); convst = 1'b1; step(1); convst = 1'b0;
        chk("R8", "early convst ignored", phase, 1);
        wait_phase(3); step(5);
        chk("R7", "wait busy low", busy, 0);
        chk("R7", "still waiting", phase, 3);
        chk("R10", "no done at wait", done_cnt, 0);
        convst = 1'b1; step(1); convst = 1'b0;
        chk("R7", "convst resumes busy", busy, 1);
        chk("R7", "offset phase", phase, 4);
        wait_phase(0); step(2);
        chk("R7", "busy width", busy_cnt, DAC_CYC + GAIN_CYC + OFFSET_CYC);
        chk("R10", "done count", done_cnt, 1);

        // R7 system gain+offset, with R9 start during wait.
        cal_mode = 3'b101; clear_counts();
        sw_go("R7");
        wait_phase(3); step(1);
        sw_start = 1'b1; step(1); sw_start = 1'b0;
        cur_req = "R9";
        chk("R9", "start in wait ignored", phase, 3);
        step(2);
        convst = 1'b1; step(1); convst = 1'b0;
        wait_phase(0); step(2);
        chk("R7", "gain+offset width", busy_cnt, GAIN_CYC + OFFSET_CYC);

        // R9 start and mode change while busy; R11 bipolar target.
        cur_req = "R9"; cal_mode = 3'b010; bipolar = 1'b1; clear_counts();
        sw_go("R9");
        cal_mode = 3'b000; bipolar = 1'b0;
        sw_start = 1'b1; step(1); sw_start = 1'b0;
        chk("R11", "bipolar midscale", trim_point, 2);
        wait_phase(0); step(2);
        chk("R9", "busy width unchanged", busy_cnt, OFFSET_CYC);

        // R2 abort mid-run and restart through the same pulse.
        cur_req = "R2"; cal_mode = 3'b000; clear_counts();
        sw_go("R2");
        step(5);
        cal_pin = 1'b0; step(1);
        chk("R2", "abort phase", phase, 0);
        chk("R2", "abort busy", busy, 0);
        chk("R2", "abort no done", done, 0);
        step(1);
        cal_pin = 1'b1; step(1);
        chk("R3", "restart busy", busy, 1);
        wait_phase(0); step(2);
        chk("R10", "done only once", done_cnt, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule